// File: doc/BRIEF.md
# Serial Register Target with 3-Wire and 4-Wire Read-Back

This block is an SPI target that gives a serial master read and write access to a 64-entry register space of byte-wide registers. The master pulls chip select low, clocks in a command byte and then clocks data bytes in either direction. The register address advances after every data byte, so any number of consecutive registers can be moved in one selection. All serial inputs are oversampled by the local system clock. Every register access appears on a simple parallel port as a one-cycle strobe. A write presents the address and data together. A read presents the address, and the data must come back combinationally in the same cycle.

Read data leaves on one serial output bit that has two enables. In 4-wire operation the dedicated output pin is enabled. In 3-wire operation (selected by a static mode input) the shared data line is enabled instead, so the master releases it during read data bytes. Neither enable is ever active while a command byte or write data is being received, or while chip select is high.

Top module: `spi_reg_target`

## Requirements
- R1: After reset both output enables are low and neither register strobe fires.
- R2: The first byte after chip select falls is the command: bit 7 set means write and clear means read, bits 6..1 are the register address, and bit 0 has no effect on the transfer.
- R3: A single write takes 16 serial clocks. The data byte follows the command directly, is received MSB first on the rising serial clock edge, and produces exactly one write strobe.
- R4: For a read, the addressed register is shifted out MSB first during the byte after the command. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R5: In a burst, the address increments by one after each data byte and wraps from 63 to 0, in both directions.
- R6: When chip select rises partway through a byte, that partial byte is dropped and causes no write.
- R7: In 4-wire mode, read data bytes enable the dedicated output and keep the shared-line enable low.
- R8: In 3-wire mode, read data bytes enable the shared line and keep the dedicated output enable low.
- R9: Both output enables stay low while chip select is high, during the command byte and during write transfers.
- R10: The write strobe and the read strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| spc | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in (the shared data line in 3-wire mode) |
| threeWire | input | 1 | 1 selects 3-wire read-back on the shared line |
| txBit | output | 1 | Serial read data bit |
| sdoOe | output | 1 | Enable for the dedicated serial output (4-wire) |
| sdioOe | output | 1 | Enable for driving the shared data line (3-wire) |
| regAddr | output | 6 | Register address for the current strobe |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Data for the register write |
| regRdEn | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Register contents for regAddr, valid in the same cycle |

## Verification
The checker watches the output enables and strobes on every cycle. It confirms that the two enables are never active together and that each follows the mode input. It also confirms that a write strobe never coincides with an enabled output or with a read strobe, and that both enables are low once chip select has been high for a few cycles. Behaviour that depends on the content of a transfer can only be shown by the bench scenarios. This covers command decoding, MSB-first ordering, address increment and wrap-around, and the dropping of partial bytes. The bench checks it by reading back through a register model and comparing with bytes predicted from the requests it issued.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  // strobes from the serial-timing control to the datapath
  typedef struct packed {
    logic sample;    // rising serial clock edge: take one bit in
    logic drive;     // falling serial clock edge: advance the output bit
    logic cmdDone;   // the command byte is complete this cycle
    logic dataDone;  // a data byte is complete this cycle
    logic abort;     // chip select is inactive
    logic inData;    // the transfer is past its command byte
  } spiStrobe_t;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       spc,
  input  logic       sdi,
  output logic       sdiSync,
  output spiStrobe_t strobe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic csMeta, csSync;
  logic spcMeta, spcSync, spcDly;
  logic sdiMeta;
  logic [CNT_W-1:0] bitCnt;
  logic inData;
  logic active, spcRise, spcFall, lastBit;

  // two-stage synchronisers, the clock has one more stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csMeta  <= 1'b1;
      csSync  <= 1'b1;
      spcMeta <= 1'b1;
      spcSync <= 1'b1;
      spcDly  <= 1'b1;
      sdiMeta <= 1'b0;
      sdiSync <= 1'b0;
    end else begin
      csMeta  <= csN;
      csSync  <= csMeta;
      spcMeta <= spc;
      spcSync <= spcMeta;
      spcDly  <= spcSync;
      sdiMeta <= sdi;
      sdiSync <= sdiMeta;
    end
  end

  assign active  = !csSync;
  assign spcRise = active && spcSync && !spcDly;
  assign spcFall = active && !spcSync && spcDly;
  assign lastBit = (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      inData <= 1'b0;
    end else if (!active) begin
      bitCnt <= '0;
      inData <= 1'b0;
    end else if (spcRise) begin
      bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);
      if (lastBit) inData <= 1'b1;
    end
  end

  always_comb begin
    strobe.sample   = spcRise;
    // the first falling edge of a byte presents the MSB already loaded
    strobe.drive    = spcFall && (bitCnt != '0);
    strobe.cmdDone  = spcRise && lastBit && !inData;
    strobe.dataDone = spcRise && lastBit && inData;
    strobe.abort    = !active;
    strobe.inData   = inData;
  end
endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strobe,
  input  logic              sdiBit,
  input  logic [DATA_W-1:0] regRdData,
  output logic              txBit,
  output logic              isWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] rxShift, rxNext, txShift;
  logic [ADDR_W-1:0] addrQ;

  assign rxNext = {rxShift[MSB-1:0], sdiBit};

  always_comb begin
    regWrEn   = strobe.dataDone && isWrite;
    regRdEn   = (strobe.cmdDone && !rxNext[MSB]) || (strobe.dataDone && !isWrite);
    regWrData = rxNext;
    if (strobe.cmdDone)
      regAddr = rxNext[MSB-1 -: ADDR_W];
    else if (strobe.dataDone && !isWrite)
      regAddr = addrQ + ADDR_W'(1);  // fetch ahead for the next read byte
    else
      regAddr = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addrQ   <= '0;
      isWrite <= 1'b0;
    end else if (strobe.abort) begin
      rxShift <= '0;
      isWrite <= 1'b0;
    end else if (strobe.sample) begin
      rxShift <= rxNext;
      if (strobe.cmdDone) begin
        isWrite <= rxNext[MSB];
        addrQ   <= rxNext[MSB-1 -: ADDR_W];
      end else if (strobe.dataDone) begin
        addrQ <= addrQ + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= '0;
    else if (strobe.abort) txShift <= '0;
    else if (regRdEn)      txShift <= regRdData;
    else if (strobe.drive) txShift <= {txShift[MSB-1:0], 1'b0};
  end

  assign txBit = txShift[MSB];
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              spc,
  input  logic              sdi,
  input  logic              threeWire,
  output logic              txBit,
  output logic              sdoOe,
  output logic              sdioOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);
  spiStrobe_t strobe;
  logic sdiSync, isWrite, readPhase;

  spi_reg_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .spc(spc), .sdi(sdi),
    .sdiSync(sdiSync), .strobe(strobe)
  );

  spi_reg_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdiBit(sdiSync),
    .regRdData(regRdData), .txBit(txBit), .isWrite(isWrite),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn)
  );

  assign readPhase = strobe.inData && !isWrite && !strobe.abort;
  assign sdoOe     = readPhase && !threeWire;
  assign sdioOe    = readPhase && threeWire;
endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic threeWire,
  input logic sdoOe,
  input logic sdioOe,
  input logic regWrEn,
  input logic regRdEn
);
  logic [2:0] csHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 csHighCnt <= '0;
    else if (!csN)             csHighCnt <= '0;
    else if (csHighCnt != 3'd7) csHighCnt <= csHighCnt + 3'd1;
  end

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  assert_enable_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoOe && sdioOe));

  assert_four_wire_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    sdoOe |-> !threeWire);

  assert_three_wire_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> threeWire);

  assert_quiet_when_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csHighCnt >= 3'd4) |-> !(sdoOe || sdioOe));

  assert_no_drive_while_writing_R9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !(sdoOe || sdioOe));
endmodule

bind spi_reg_target spi_reg_checker i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .threeWire(threeWire),
  .sdoOe(sdoOe), .sdioOe(sdioOe), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/test_spi_reg_target.sv
module test_spi_reg_target;
  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, spc = 1'b1, sdi = 1'b0, threeWire = 1'b0;
  logic txBit, sdoOe, sdioOe, regWrEn, regRdEn;
  logic [5:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] mem [64];
  logic [7:0] expMem [64];
  logic [7:0] wbuf [8];
  int nChk = 0, nFail = 0, wrCount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_reg_target i_spi_reg_target (
    .clk(clk), .rstN(rstN), .csN(csN), .spc(spc), .sdi(sdi),
    .threeWire(threeWire), .txBit(txBit), .sdoOe(sdoOe), .sdioOe(sdioOe),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  assign regRdData = mem[regAddr];
  always @(posedge clk) begin
    if (regWrEn) mem[regAddr] <= regWrData;
    if (regWrEn) wrCount <= wrCount + 1;
  end

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 5) & 8'hff);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: drive after falling edge, sample just before rising edge
  task automatic serialBit(input bit b, output bit got, output bit oe4, output bit oe3);
    spc = 1'b0;
    sdi = b;
    waitClk(HALF);
    got = txBit;
    oe4 = sdoOe;
    oe3 = sdioOe;
    spc = 1'b1;
    waitClk(HALF);
  endtask

  // wr: direction, n: data bytes, tw: 3-wire, dc: don't-care bit, cut: extra partial bits
  task automatic xfer(bit wr, logic [5:0] a, int n, bit tw, bit dc, int cut);
    logic [7:0] cmd, rbyte;
    bit got, oe4, oe3, oeBad, anyOe;
    int wr0;
    wr0 = wrCount;
    threeWire = tw;
    waitClk(2);
    csN = 1'b0;
    waitClk(4);
    cmd = {wr, a, dc};
    anyOe = 0;
    for (int i = 7; i >= 0; i--) begin
      serialBit(cmd[i], got, oe4, oe3);
      anyOe |= oe4 | oe3;
    end
    check(!anyOe, "R9 enable during command", int'(anyOe), 0);
    for (int k = 0; k < n; k++) begin
      anyOe = 0;
      oeBad = 0;
      for (int i = 7; i >= 0; i--) begin
        serialBit(wr ? wbuf[k][i] : (tw ? 1'b0 : 1'(($urandom % 2))), got, oe4, oe3);
        rbyte[i] = got;
        anyOe |= oe4 | oe3;
        if (tw) oeBad |= !oe3 || oe4;
        else    oeBad |= !oe4 || oe3;
      end
      if (wr) begin
        check(!anyOe, "R9 enable during write data", int'(anyOe), 0);
      end else begin
        if (tw) check(!oeBad, "R8 3-wire enables", int'(oeBad), 0);
        else    check(!oeBad, "R7 4-wire enables", int'(oeBad), 0);
        check(rbyte == expMem[6'(a + 6'(k))], "R4/R5 read data", rbyte, expMem[6'(a + 6'(k))]);
      end
    end
    for (int i = 0; i < cut; i++) serialBit(1'(($urandom % 2)), got, oe4, oe3);
    waitClk(4);
    csN = 1'b1;
    waitClk(8);
    check(!(sdoOe || sdioOe), "R9 enable after deselect", int'(sdoOe || sdioOe), 0);
    if (wr) begin
      for (int k = 0; k < n; k++) expMem[6'(a + 6'(k))] = wbuf[k];
      check(wrCount - wr0 == n, "R3/R6 write strobe count", wrCount - wr0, n);
    end else begin
      check(wrCount == wr0, "R2 read causes no write", wrCount - wr0, 0);
    end
  endtask

  initial begin
    process::self().srandom(32'h5EED);
    for (int i = 0; i < 64; i++) begin
      mem[i] = initVal(i);
      expMem[i] = initVal(i);
    end
    waitClk(5);
    // R1: reset state
    check(!sdoOe && !sdioOe, "R1 enables in reset", int'(sdoOe | sdioOe), 0);
    check(!regWrEn && !regRdEn, "R1 strobes in reset", int'(regWrEn | regRdEn), 0);
    rstN = 1'b1;
    waitClk(5);
    check(!sdoOe && !sdioOe && !regWrEn && !regRdEn, "R1 idle after reset", 1, 0);

    // R3, R2: single write with don't-care bit set, then read back with it clear
    wbuf[0] = 8'hA5;
    xfer(1'b1, 6'd5, 1, 1'b0, 1'b1, 0);
    xfer(1'b0, 6'd5, 1, 1'b0, 1'b0, 0);
    // R2: don't-care set on a read, R8: 3-wire read back
    xfer(1'b0, 6'd5, 1, 1'b1, 1'b1, 0);

    // R5: burst writes and reads across the 63 -> 0 wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h80; wbuf[2] = 8'h01; wbuf[3] = 8'hFE;
    xfer(1'b1, 6'd62, 4, 1'b1, 1'b0, 0);
    xfer(1'b0, 6'd62, 4, 1'b0, 1'b0, 0);
    xfer(1'b0, 6'd61, 5, 1'b1, 1'b0, 0);

    // R6: second byte cut after 5 bits, only the first one lands
    wbuf[0] = 8'h3C; wbuf[1] = 8'hFF;
    xfer(1'b1, 6'd20, 1, 1'b0, 1'b0, 5);
    xfer(1'b0, 6'd20, 2, 1'b0, 1'b0, 0);
    // R6: command itself cut
    xfer(1'b1, 6'd30, 0, 1'b0, 1'b0, 0);
    csN = 1'b0; waitClk(4);
    begin
      bit g, o4, o3;
      for (int i = 0; i < 3; i++) serialBit(1'b1, g, o4, o3);
    end
    csN = 1'b1; waitClk(8);
    xfer(1'b0, 6'd30, 1, 1'b0, 1'b0, 0);

    // constrained random transfers
    for (int t = 0; t < 60; t++) begin
      int n;
      n = 1 + ($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      xfer(1'($urandom % 2), 6'($urandom), n, 1'($urandom % 2), 1'($urandom % 2),
           ($urandom % 4 == 0) ? int'($urandom % 8) : 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        nFail++;
        nChk++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule